// File: doc/BRIEF.md
# Quadword Add/Subtract Unit

This block is a 128-bit integer execution unit for a vector pipeline. Each operation takes three 128-bit sources, A, B and C, plus two opcode fields, and returns one 128-bit result. There are eight operations: add and subtract, each in four forms.

- The modulo form returns the wrapped sum.
- The carry form returns only the carry out of the full-width sum, placed in bit 0.
- The extended modulo form adds a carry-in taken from bit 0 of C.
- The extended carry form uses that carry-in and returns the carry.

Subtraction is computed as A plus the complement of B plus a carry-in. The carry-in is 1 for the plain forms and C[0] for the extended ones. A carry out of a subtraction therefore means that no borrow occurred.

The unit has one registered output stage behind a valid/ready stream on each side. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid` after that same edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds and no new operation is accepted. An opcode combination that is not defined yields a zero result with `out_illegal` set.

Top module: `qas_unit`

## Requirements
- R1: With op_major = 4 and op_minor = 4, the result is (A + B) mod 2^128.
- R2: With op_major = 4 and op_minor = 20, the result is (A + ~B + 1) mod 2^128, which equals A - B with wrap-around.
- R3: With op_major = 30 (add) or 31 (subtract) and op_minor[0] = 0, the result is (A + B + C[0]) or (A + ~B + C[0]), both mod 2^128. Bits 127:1 of C have no effect on the result.
- R4: With op_major = 4, op_minor = 5 gives the add carry and op_minor = 21 gives the subtract carry. The result has bits 127:1 zero and bit 0 set to the carry. For add, the carry is 1 exactly when ~A < B unsigned. For subtract, it is 1 exactly when A >= B unsigned.
- R5: With op_major = 30 or 31 and op_minor[0] = 1, bits 127:1 of the result are zero. For 30, bit 0 is 1 when ~A < B, or when C[0] = 1 and A + B is all ones. For 31, bit 0 is 1 when A > B, or when C[0] = 1 and A = B.
- R6: Any other combination of op_major and op_minor gives a zero result with out_illegal = 1. Every defined operation gives out_illegal = 0.
- R7: An operation accepted on a rising edge where in_valid and in_ready are both high is presented with out_valid = 1 right after that edge.
- R8: While out_valid = 1 and out_ready = 0, in_ready is 0, and out_result and out_illegal hold their values.
- R9: A synchronous reset (rst = 1 on a rising edge) clears out_valid. After reset, in_ready is 1.
- R10: For op_major 30 and 31, only op_minor[0] is decoded. Bits 5:1 of op_minor have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| op_major | input | 6 | Major opcode: 4 two-source, 30 extended add, 31 extended subtract |
| op_minor | input | 6 | Minor opcode; bit 0 selects the carry variant for the extended majors |
| src_a | input | 128 | Source A |
| src_b | input | 128 | Source B |
| src_c | input | 128 | Source C; only bit 0 is used, as the carry-in |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 128 | Sum or carry word |
| out_illegal | output | 1 | Opcode combination was not defined |

## Verification
Several rules are checked on every cycle:

- Accepting an operation produces out_valid on the next edge.
- A stalled output stays stable and keeps in_ready low.
- An illegal result is always zero.
- A plain add matches the wrapped sum of its sources.
- A plain carry result has its upper 127 bits zero.

Some behaviour shows only in the bench's directed scenarios:

- The carry values at the exact boundaries, where ~A equals B, A equals B, and the all-ones sum with and without a carry-in.
- The fact that the high bits of C and the upper minor bits of the extended majors are ignored.
- The reset clearing a result that is held under stall.

// File: rtl/qas_pkg.sv
package qas_pkg;
  localparam logic [5:0] MAJ_BASIC   = 6'd4;
  localparam logic [5:0] MAJ_EXT_ADD = 6'd30;
  localparam logic [5:0] MAJ_EXT_SUB = 6'd31;
  localparam logic [5:0] MIN_ADD     = 6'd4;
  localparam logic [5:0] MIN_ADDC    = 6'd5;
  localparam logic [5:0] MIN_SUB     = 6'd20;
  localparam logic [5:0] MIN_SUBC    = 6'd21;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_SRCC = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic     illegal;
    logic     invert_b;
    logic     carry_only;
    cin_sel_e cin_sel;
  } qas_ctrl_t;
endpackage

// File: rtl/qas_decode.sv
module qas_decode
  import qas_pkg::*;
(
  input  logic [5:0] op_major,
  input  logic [5:0] op_minor,
  output qas_ctrl_t  ctrl
);
  always_comb begin
    ctrl = '{illegal: 1'b0, invert_b: 1'b0, carry_only: 1'b0, cin_sel: CIN_ZERO};
    unique case (op_major)
      MAJ_BASIC: begin
        unique case (op_minor)
          MIN_ADD:  ctrl.cin_sel = CIN_ZERO;
          MIN_ADDC: ctrl.carry_only = 1'b1;
          MIN_SUB: begin
            ctrl.invert_b = 1'b1;
            ctrl.cin_sel  = CIN_ONE;
          end
          MIN_SUBC: begin
            ctrl.invert_b   = 1'b1;
            ctrl.cin_sel    = CIN_ONE;
            ctrl.carry_only = 1'b1;
          end
          default: ctrl.illegal = 1'b1;
        endcase
      end
      MAJ_EXT_ADD: begin
        ctrl.cin_sel    = CIN_SRCC;
        ctrl.carry_only = op_minor[0];
      end
      MAJ_EXT_SUB: begin
        ctrl.invert_b   = 1'b1;
        ctrl.cin_sel    = CIN_SRCC;
        ctrl.carry_only = op_minor[0];
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/qas_slice.sv
module qas_slice #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
  end
endmodule

// File: rtl/qas_core.sv
module qas_core
  import qas_pkg::*;
#(
  parameter int WIDTH  = 128,
  parameter int SLICES = 2
) (
  input  qas_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_lsb,
  output logic [WIDTH-1:0] result
);
  localparam int SW = WIDTH / SLICES;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [SLICES:0]  chain;

  always_comb begin
    b_eff = ctrl.invert_b ? ~b : b;
    unique case (ctrl.cin_sel)
      CIN_ONE:  chain[0] = 1'b1;
      CIN_SRCC: chain[0] = c_lsb;
      default:  chain[0] = 1'b0;
    endcase
  end

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    qas_slice #(.W(SW)) u_slice (
      .a    (a[g*SW +: SW]),
      .b    (b_eff[g*SW +: SW]),
      .cin  (chain[g]),
      .sum  (sum[g*SW +: SW]),
      .cout (chain[g+1])
    );
  end

  always_comb begin
    if (ctrl.illegal)         result = '0;
    else if (ctrl.carry_only) result = {{(WIDTH-1){1'b0}}, chain[SLICES]};
    else                      result = sum;
  end
endmodule

// File: rtl/qas_unit.sv
module qas_unit
  import qas_pkg::*;
#(
  parameter int WIDTH  = 128,
  parameter int SLICES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [5:0]       op_major,
  input  logic [5:0]       op_minor,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] src_c,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_illegal
);
  qas_ctrl_t        ctrl;
  logic [WIDTH-1:0] comb_result;

  qas_decode u_dec (
    .op_major (op_major),
    .op_minor (op_minor),
    .ctrl     (ctrl)
  );

  qas_core #(.WIDTH(WIDTH), .SLICES(SLICES)) u_core (
    .ctrl   (ctrl),
    .a      (src_a),
    .b      (src_b),
    .c_lsb  (src_c[0]),
    .result (comb_result)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= comb_result;
        out_illegal <= ctrl.illegal;
      end
    end
  end
endmodule

// File: rtl/qas_checker.sv
module qas_checker #(
  parameter int WIDTH = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [5:0]       op_major,
  input logic [5:0]       op_minor,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_illegal
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_result == '0); // R6

  AST_PLAIN_ADD: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && op_major == 6'd4 && op_minor == 6'd4
    |=> out_result == $past(src_a + src_b) && !out_illegal); // R1

  AST_CARRY_UPPER: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && op_major == 6'd4 && (op_minor == 6'd5 || op_minor == 6'd21)
    |=> out_result[WIDTH-1:1] == '0); // R4
endmodule

bind qas_unit qas_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .op_major    (op_major),
  .op_minor    (op_minor),
  .src_a       (src_a),
  .src_b       (src_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/sim_qas_unit.sv
`timescale 1ns/1ps
module sim_qas_unit;
  localparam logic [127:0] ONES = {128{1'b1}};

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [5:0]   op_major;
  logic [5:0]   op_minor;
  logic [127:0] src_a, src_b, src_c;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_result;
  logic         out_illegal;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  qas_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_major(op_major), .op_minor(op_minor),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] maj, input logic [5:0] mn,
                        input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                        input logic [127:0] exp, input logic exp_ill, input string tag);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    op_major = maj; op_minor = mn; src_a = a; src_b = b; src_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_result === exp && out_illegal === exp_ill,
          tag, {out_result}, exp);
  endtask

  function automatic logic [127:0] cbit(input bit v);
    return {127'b0, v};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R9 reset state",
          {126'b0, out_valid, in_ready}, 128'b01);
  endtask

  task automatic t_add_mod();
    logic [127:0] a = 128'h0123_4567_89ab_cdef_ffff_ffff_ffff_ffff;
    logic [127:0] b = 128'h1;
    run_op(6'd4, 6'd4, a, b, '0, a + b, 1'b0, "R1 add cross-half carry");
    run_op(6'd4, 6'd4, ONES, 128'd5, '0, 128'd4, 1'b0, "R1 add wrap");
  endtask

  task automatic t_sub_mod();
    run_op(6'd4, 6'd20, 128'd100, 128'd58, '0, 128'd42, 1'b0, "R2 sub");
    run_op(6'd4, 6'd20, 128'd3, 128'd5, '0, 128'd3 - 128'd5, 1'b0, "R2 sub borrow wrap");
  endtask

  task automatic t_ext_mod();
    logic [127:0] a = 128'hffff_ffff_ffff_ffff_0000_0000_0000_0010;
    logic [127:0] b = 128'h0000_0000_0000_0001_ffff_ffff_ffff_fff0;
    run_op(6'd30, 6'd0, a, b, 128'hdead_0001, a + b + 128'd1, 1'b0, "R3 ext add cin=1 C high ignored");
    run_op(6'd30, 6'd0, a, b, 128'hdead_0000, a + b, 1'b0, "R3 ext add cin=0");
    run_op(6'd31, 6'd0, 128'd10, 128'd3, ONES - 128'd1, 128'd6, 1'b0, "R3 ext sub cin=0 gives A-B-1");
    run_op(6'd31, 6'd0, 128'd10, 128'd3, 128'd1, 128'd7, 1'b0, "R3 ext sub cin=1");
    run_op(6'd30, 6'b111110, 128'd7, 128'd8, 128'd1, 128'd16, 1'b0, "R10 upper minor bits ignored");
  endtask

  task automatic t_carry();
    logic [127:0] a = 128'h8000_0000_0000_0000_0000_0000_0000_1234;
    run_op(6'd4, 6'd5, a, ~a, '0, cbit(1'b0), 1'b0, "R4 add carry ~A==B");
    run_op(6'd4, 6'd5, a, ~a + 128'd1, '0, cbit(1'b1), 1'b0, "R4 add carry ~A<B");
    run_op(6'd4, 6'd21, a, a, '0, cbit(1'b1), 1'b0, "R4 sub carry A==B");
    run_op(6'd4, 6'd21, a, a + 128'd1, '0, cbit(1'b0), 1'b0, "R4 sub carry A<B");
  endtask

  task automatic t_ext_carry();
    logic [127:0] a = 128'h5555_0000_1111_2222_3333_4444_5555_6666;
    run_op(6'd30, 6'd1, a, ~a, 128'd1, cbit(1'b1), 1'b0, "R5 ext add carry all-ones cin=1");
    run_op(6'd30, 6'd1, a, ~a, 128'd0, cbit(1'b0), 1'b0, "R5 ext add carry all-ones cin=0");
    run_op(6'd31, 6'd1, a, a, 128'd1, cbit(1'b1), 1'b0, "R5 ext sub carry A==B cin=1");
    run_op(6'd31, 6'd1, a, a, 128'd2, cbit(1'b0), 1'b0, "R5 ext sub carry A==B cin=0");
    run_op(6'd31, 6'd1, a + 128'd1, a, 128'd0, cbit(1'b1), 1'b0, "R5 ext sub carry A>B");
  endtask

  task automatic t_illegal();
    run_op(6'd7, 6'd4, 128'd1, 128'd2, '0, '0, 1'b1, "R6 unknown major");
    run_op(6'd4, 6'd6, 128'd1, 128'd2, '0, '0, 1'b1, "R6 unknown minor");
  endtask

  task automatic t_stall();
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    op_major = 6'd4; op_minor = 6'd4; src_a = 128'd20; src_b = 128'd22;
    @(negedge clk);
    check(out_valid === 1'b1 && out_result === 128'd42, "R7 result after accept", out_result, 128'd42);
    check(in_ready === 1'b0, "R8 in_ready low under stall", {127'b0, in_ready}, 128'd0);
    src_a = 128'd1000;
    @(negedge clk);
    check(out_result === 128'd42 && out_valid === 1'b1, "R8 hold under stall", out_result, 128'd42);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drain", {127'b0, out_valid}, 128'd0);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R9 reset clears held result",
          {126'b0, out_valid, in_ready}, 128'b01);
    out_ready = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    op_major = '0; op_minor = '0; src_a = '0; src_b = '0; src_c = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add_mod();
    t_sub_mod();
    t_ext_mod();
    t_carry();
    t_ext_carry();
    t_illegal();
    t_stall();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule